// File: doc/BRIEF.md
# Wake Event Latch Unit

This block collects wake-up events from a group of up to 32 sources, such as external pins or internal peripheral interrupt lines, and turns them into one request to leave a low-power mode. Every source has its own enable bit and its own polarity bit. The polarity bit chooses which transition counts as an event. Each input passes through a two-flop synchronizer. When the chosen transition is seen, a raw status bit is set. That bit stays set until software clears it by writing a 1.

The raw status latches whether or not the source is enabled. The masked status is the raw status ANDed with the enable vector. The wake output is asserted while any masked bit is set. A chip uses two instances of the same module: one for pins and one for internal sources. They differ only in the polarity value loaded at reset, which is set by a parameter. Software writes through one port: an enable select, a selector and a data word. The current state of the enable, polarity, raw status and masked status registers is always visible on the outputs.

Top module: `wake_event_latch`

## Requirements
- R1: After reset, `enable` is all zeros, `raw_status`, `masked_status` and `wake` are zero, and `polarity` equals the parameter `POL_RESET`.
- R2: A write with `wr_sel` = 0 loads `wr_data` into `enable`. A write with `wr_sel` = 1 loads `wr_data` into `polarity`. Both take effect at the clock edge that samples the write.
- R3: A source whose polarity bit is 1 sets its raw bit on a low-to-high transition and ignores high-to-low. A polarity bit of 0 does the opposite.
- R4: A raw bit latches even when its enable bit is 0. Enabling a source that already has a pending raw bit asserts `wake` right after the enabling write.
- R5: A write with `wr_sel` = 2 clears every raw bit where `wr_data` is 1 and leaves the bits where it is 0. Writing back the value just read clears all latched events.
- R6: If a new event and a clear write hit the same raw bit in the same cycle, the bit stays set.
- R7: `masked_status` always equals `raw_status & enable`. `wake` is the OR of `masked_status`, so it stays high until every enabled latched bit has been cleared.
- R8: An input transition driven between two clock edges shows up in `raw_status` after the third rising edge that follows it, and not after the second.
- R9: A write with `wr_sel` = 3 changes none of `enable`, `polarity` or `raw_status`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_in | input | NUM_SRC | Asynchronous event source lines |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_sel | input | 2 | Write target: 0 enable, 1 polarity, 2 raw clear, 3 none |
| wr_data | input | NUM_SRC | Write data |
| enable | output | NUM_SRC | Per-source enable register |
| polarity | output | NUM_SRC | Per-source polarity register (1 rising, 0 falling) |
| raw_status | output | NUM_SRC | Latched events, cleared by writing 1 |
| masked_status | output | NUM_SRC | Latched events gated by enable |
| wake | output | 1 | Wake request, high while any masked bit is set |

## Verification
The assertions check four things on every cycle. They check the masked/raw/enable relation and the OR into `wake`. They check that a raw bit is never cleared except by a clear write that names it. They check that every detected edge is latched on the next cycle, even when a clear write arrives at the same time. They also check how the enable and no-op writes land. Some behaviour only the bench scenarios can show: that polarity actually picks the transition direction, the exact three-edge latency through the synchronizer, and that an event which was pending while its source was disabled raises `wake` when the source is enabled.

// File: rtl/wkl_pkg.sv
package wkl_pkg;
  // write target selector
  typedef enum logic [1:0] {
    WKL_SEL_ENABLE   = 2'd0,
    WKL_SEL_POLARITY = 2'd1,
    WKL_SEL_RAW_CLR  = 2'd2,
    WKL_SEL_NONE     = 2'd3
  } wkl_sel_e;
endpackage

// File: rtl/wkl_sync.sv
// Multi-stage synchronizer. No reset, so the chain keeps following the
// pins during reset and settles before reset is released.
module wkl_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) stage_q[0] <= d;

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) stage_q[i] <= stage_q[i-1];
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/wkl_edge.sv
// Per-bit transition detector with a selectable direction.
module wkl_edge #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] pol,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) prev_q <= cur;

  always_comb begin
    hit = (pol & cur & ~prev_q) | (~pol & ~cur & prev_q);
  end
endmodule

// File: rtl/wkl_cfg.sv
// Enable and polarity registers.
module wkl_cfg
  import wkl_pkg::*;
#(
  parameter int          W         = 32,
  parameter logic [W-1:0] POL_RESET = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] en_q,
  output logic [W-1:0] en_nxt,
  output logic [W-1:0] pol_q
);
  logic [W-1:0] pol_nxt;

  always_comb begin
    en_nxt  = en_q;
    pol_nxt = pol_q;
    if (wr_en) begin
      case (wkl_sel_e'(wr_sel))
        WKL_SEL_ENABLE:   en_nxt  = wr_data;
        WKL_SEL_POLARITY: pol_nxt = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      pol_q <= POL_RESET;
    end else begin
      en_q  <= en_nxt;
      pol_q <= pol_nxt;
    end
  end
endmodule

// File: rtl/wkl_status.sv
// Raw event latch (set wins over clear), masked copy and wake flag.
module wkl_status #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] hit,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] en_nxt,
  output logic [W-1:0] raw_q,
  output logic [W-1:0] masked_q,
  output logic         wake_q
);
  logic [W-1:0] raw_nxt;
  logic [W-1:0] masked_nxt;

  always_comb begin
    raw_nxt    = (raw_q & ~clr) | hit;
    masked_nxt = raw_nxt & en_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q    <= '0;
      masked_q <= '0;
      wake_q   <= 1'b0;
    end else begin
      raw_q    <= raw_nxt;
      masked_q <= masked_nxt;
      wake_q   <= |masked_nxt;
    end
  end
endmodule

// File: rtl/wake_event_latch.sv
module wake_event_latch
  import wkl_pkg::*;
#(
  parameter int                 NUM_SRC     = 32,
  parameter int                 SYNC_STAGES = 2,
  parameter logic [NUM_SRC-1:0] POL_RESET   = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [NUM_SRC-1:0] wr_data,
  output logic [NUM_SRC-1:0] enable,
  output logic [NUM_SRC-1:0] polarity,
  output logic [NUM_SRC-1:0] raw_status,
  output logic [NUM_SRC-1:0] masked_status,
  output logic               wake
);
  localparam int W = NUM_SRC;

  logic [W-1:0] sync_vec;
  logic [W-1:0] edge_vec;
  logic [W-1:0] clr_vec;
  logic [W-1:0] en_nxt;

  assign clr_vec = (wr_en && wkl_sel_e'(wr_sel) == WKL_SEL_RAW_CLR) ? wr_data : '0;

  wkl_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (src_in),
    .q   (sync_vec)
  );

  wkl_edge #(.W(W)) u_edge (
    .clk (clk),
    .cur (sync_vec),
    .pol (polarity),
    .hit (edge_vec)
  );

  wkl_cfg #(.W(W), .POL_RESET(POL_RESET)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .en_q    (enable),
    .en_nxt  (en_nxt),
    .pol_q   (polarity)
  );

  wkl_status #(.W(W)) u_status (
    .clk      (clk),
    .rst      (rst),
    .hit      (edge_vec),
    .clr      (clr_vec),
    .en_nxt   (en_nxt),
    .raw_q    (raw_status),
    .masked_q (masked_status),
    .wake_q   (wake)
  );
endmodule

// File: rtl/wake_event_latch_chk.sv
module wake_event_latch_chk #(
  parameter int                 NUM_SRC   = 32,
  parameter logic [NUM_SRC-1:0] POL_RESET = '0
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [1:0]         wr_sel,
  input logic [NUM_SRC-1:0] wr_data,
  input logic [NUM_SRC-1:0] edge_vec,
  input logic [NUM_SRC-1:0] enable,
  input logic [NUM_SRC-1:0] polarity,
  input logic [NUM_SRC-1:0] raw_status,
  input logic [NUM_SRC-1:0] masked_status,
  input logic               wake
);
  logic [NUM_SRC-1:0] chk_clr;
  assign chk_clr = (wr_en && wr_sel == 2'd2) ? wr_data : '0;

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (enable == '0 && raw_status == '0 && masked_status == '0
                    && !wake && polarity == POL_RESET));

  // R7
  masked_gate_chk: assert property (@(posedge clk) disable iff (rst)
    masked_status == (raw_status & enable));

  // R7
  wake_or_chk: assert property (@(posedge clk) disable iff (rst)
    wake == (|masked_status));

  // R5
  clear_only_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(raw_status) & ~raw_status & ~$past(chk_clr)) == '0));

  // R6
  edge_latched_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((raw_status & $past(edge_vec)) == $past(edge_vec)));

  // R2
  enable_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd0) |=> (enable == $past(wr_data)));

  // R9
  noop_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd3) |=> ($stable(enable) && $stable(polarity)));
endmodule

bind wake_event_latch wake_event_latch_chk #(
  .NUM_SRC   (NUM_SRC),
  .POL_RESET (POL_RESET)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_en         (wr_en),
  .wr_sel        (wr_sel),
  .wr_data       (wr_data),
  .edge_vec      (edge_vec),
  .enable        (enable),
  .polarity      (polarity),
  .raw_status    (raw_status),
  .masked_status (masked_status),
  .wake          (wake)
);

// File: tb/wake_event_latch_bench.sv
module wake_event_latch_bench;
  localparam int          N       = 32;
  localparam int          CLK_PER = 10;
  localparam logic [N-1:0] POL    = 32'h0000_0700;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] src_in = '0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = 2'd0;
  logic [N-1:0] wr_data = '0;
  logic [N-1:0] enable, polarity, raw_status, masked_status;
  logic         wake;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #(CLK_PER/2) clk = ~clk;

  wake_event_latch #(.NUM_SRC(N), .SYNC_STAGES(2), .POL_RESET(POL)) u_wake_event_latch (
    .clk(clk), .rst(rst), .src_in(src_in), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .enable(enable), .polarity(polarity),
    .raw_status(raw_status), .masked_status(masked_status), .wake(wake)
  );

  // reference state built from the requirements
  logic [N-1:0] m_s1, m_s2, m_prev, m_en, m_pol, m_raw;

  function automatic logic [N-1:0] f_events(logic [N-1:0] cur, logic [N-1:0] prv,
                                            logic [N-1:0] pl);
    return (pl & cur & ~prv) | (~pl & ~cur & prv);
  endfunction

  function automatic logic [N-1:0] f_clear(logic we, logic [1:0] sel, logic [N-1:0] d);
    return (we && sel == 2'd2) ? d : '0;
  endfunction

  always @(posedge clk) begin
    m_s1   <= src_in;
    m_s2   <= m_s1;
    m_prev <= m_s2;
    if (rst) begin
      m_en  <= '0;
      m_pol <= POL;
      m_raw <= '0;
    end else begin
      if (wr_en && wr_sel == 2'd0) m_en  <= wr_data;
      if (wr_en && wr_sel == 2'd1) m_pol <= wr_data;
      m_raw <= (m_raw & ~f_clear(wr_en, wr_sel, wr_data)) | f_events(m_s2, m_prev, m_pol);
    end
  end

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // continuous comparison against the reference
  always @(negedge clk) begin
    if (!rst && cyc > 4) begin
      chk("R2 enable",        enable,        m_en);
      chk("R2 polarity",      polarity,      m_pol);
      chk("R3 raw_status",    raw_status,    m_raw);
      chk("R7 masked_status", masked_status, m_raw & m_en);
      chk("R7 wake",          {{(N-1){1'b0}}, wake}, {{(N-1){1'b0}}, |(m_raw & m_en)});
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 60000) begin
      n_fail++;
      $display("FAIL watchdog actual %0d cycles expected under 60000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [N-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  logic [N-1:0] snap_en, snap_pol, snap_raw;

  initial begin
    void'($urandom(32'd20240611));
    tick(4);
    rst = 1'b0;
    // R1 reset state
    chk("R1 enable", enable, '0);
    chk("R1 raw", raw_status, '0);
    chk("R1 masked", masked_status, '0);
    chk("R1 wake", {31'd0, wake}, 32'd0);
    chk("R1 polarity", polarity, POL);

    // R3: rising edge on a falling-polarity source is ignored
    src_in[0] = 1'b1; tick(4);
    chk("R3 rise ignored", raw_status, '0);
    // R8: falling edge latency
    src_in[0] = 1'b0; tick(2);
    chk("R8 not after two edges", raw_status, '0);
    tick(1);
    chk("R8 after three edges", raw_status, 32'h1);
    chk("R4 latched while disabled, no wake", {31'd0, wake}, 32'd0);

    // R4: enabling with a pending event wakes at once
    wr(2'd0, 32'h1);
    chk("R4 wake after enable", {31'd0, wake}, 32'd1);
    chk("R7 masked", masked_status, 32'h1);

    // R3: rising-polarity source
    src_in[8] = 1'b1; tick(3);
    chk("R3 rising latched", raw_status, 32'h101);
    chk("R7 masked gating", masked_status, 32'h1);
    src_in[8] = 1'b0; tick(4);
    chk("R3 fall ignored on rising pol", raw_status, 32'h101);

    // R5: write-one-to-clear
    wr(2'd2, 32'h0);
    chk("R5 zero clears nothing", raw_status, 32'h101);
    wr(2'd2, raw_status);
    chk("R5 readback clears all", raw_status, '0);
    chk("R5 wake drops", {31'd0, wake}, 32'd0);

    // R7: wake holds until every enabled bit cleared
    wr(2'd0, 32'h3);
    src_in[1:0] = 2'b11; tick(4);
    src_in[1:0] = 2'b00; tick(4);
    chk("R7 two latched", raw_status, 32'h3);
    wr(2'd2, 32'h1);
    chk("R7 wake holds", {31'd0, wake}, 32'd1);
    wr(2'd2, 32'h2);
    chk("R7 wake released", {31'd0, wake}, 32'd0);

    // R6: set and clear in the same cycle, set wins
    src_in[1] = 1'b1; tick(4);
    src_in[1] = 1'b0; tick(4);
    chk("R6 setup", raw_status, 32'h2);
    src_in[1] = 1'b1; tick(4);
    src_in[1] = 1'b0; tick(2);
    wr(2'd2, 32'h2);
    chk("R6 set wins", raw_status, 32'h2);
    wr(2'd2, 32'h2);
    chk("R6 plain clear after", raw_status, '0);

    // R2: polarity write
    wr(2'd1, 32'hA5A5_0000);
    chk("R2 polarity write", polarity, 32'hA5A5_0000);
    wr(2'd1, POL);

    // R9: selector 3 has no effect
    src_in[2] = 1'b1; tick(4); src_in[2] = 1'b0; tick(4);
    snap_en = enable; snap_pol = polarity; snap_raw = raw_status;
    wr(2'd3, '1);
    chk("R9 enable kept", enable, snap_en);
    chk("R9 polarity kept", polarity, snap_pol);
    chk("R9 raw kept", raw_status, snap_raw);

    // constrained random phase, checked by the reference each cycle
    for (int i = 0; i < 4000; i++) begin
      src_in = src_in ^ ($urandom & $urandom & $urandom);
      if ($urandom % 5 == 0) begin
        wr_en   = 1'b1;
        wr_sel  = 2'($urandom % 4);
        wr_data = (wr_sel == 2'd2 && ($urandom % 2 == 0)) ? raw_status : $urandom;
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    tick(2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule